// File: doc/BRIEF.md
# ADC Scan Trigger Sequencer

This block is the control side of a multi-channel analog-to-digital converter. It holds one 16-bit control word and decides when a scan begins, which channels it covers, where each result goes and when a scan is over. A scan can begin from a software write, from a single-cycle pulse on an internal synchronous trigger, or from a falling edge on an active-low external pin. That pin is brought into the clock domain through a two-stage synchronizer.

Three scan modes are supported. A one-shot scan stops by itself. An armed group scan runs once per trigger and stays armed. A continuous scan starts again as soon as it ends. Double-trigger mode replaces the channel mask with one chosen channel, converted once per start. The destination alternates between that channel's data register and a separate duplicate register.

The converter itself lies outside the block. The block drives a request with a channel number. It accepts a one-cycle done pulse with the result, then issues a one-cycle result write tagged with the channel and a duplicate flag. A scan-end interrupt pulse is raised when enabled.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the control word reads 0x0000, and `conv_req`, `res_wr_en` and `scan_end_irq` are all low.
- R2: The control word reads back as written: start bit 15, mode bits 14:13, scan-end interrupt enable bit 12, trigger enable bit 9, source select bit 8, double-trigger bit 7, group-B interrupt enable bit 6 and channel field 4:0. Reserved bits 5, 10 and 11 always read 0, whatever is written to them.
- R3: A write with bit 15 = 1 updates every field except the duplication channel field (bits 4:0), which keeps its previous value.
- R4: A scan converts the channels set in `chan_mask` once each, in ascending order. Each done pulse yields one result write, one cycle later, carrying that channel and `conv_result`. An empty mask ends the scan with no conversion.
- R5: In mode 00, and in the prohibited mode 11, the start bit returns to 0 in the cycle the scan ends.
- R6: In mode 01 the start bit stays 1 after the scan, and each later accepted trigger runs another scan.
- R7: In mode 10 a new scan begins right after each one ends, until a write with bit 15 = 0.
- R8: A hardware trigger is accepted only when bit 9 = 1. Bit 8 = 0 selects `sync_trig` and bit 8 = 1 selects the external pin; the source not selected has no effect. An accepted trigger sets the start bit.
- R9: The external pin starts a scan only on a high-to-low transition. A low pulse of 1.5 clock periods is recognized. A low pulse that spans no rising clock edge is not recognized.
- R10: Triggers that arrive while a scan is in progress are ignored.
- R11: With bit 7 = 1, each start converts only the channel given by bits 3:0, whatever the mask. The first start writes with `res_wr_dup` = 0 and the next with `res_wr_dup` = 1, and the two keep alternating.
- R12: The double-trigger toggle goes back to "first" on any write with bit 15 = 0, and on any write that changes bit 7 from 0 to 1.
- R13: `scan_end_irq` pulses for one cycle when a scan ends, only if bit 12 is set. In double-trigger mode it pulses only after the second conversion of the pair.
- R14: A write with bit 15 = 0 stops at once. In the next cycle `conv_req` is low, and a conversion that completes in the same cycle as the stop produces neither a result write nor an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | 16 | Control word write value |
| reg_rd_data | output | 16 | Control word read value |
| chan_mask | input | NCH | Channels covered by a normal scan |
| sync_trig | input | 1 | Synchronous internal trigger pulse |
| ext_trig_n | input | 1 | Asynchronous active-low external trigger pin |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | CHW | Channel being converted |
| conv_done | input | 1 | One-cycle conversion complete pulse |
| conv_result | input | RES_W | Conversion result, valid with `conv_done` |
| res_wr_en | output | 1 | Result write strobe |
| res_wr_chan | output | CHW | Channel of the result |
| res_wr_dup | output | 1 | 1 = result goes to the duplicate register |
| res_wr_data | output | RES_W | Result value |
| scan_end_irq | output | 1 | Scan-end interrupt pulse |

## Verification
Two events can fall in the same cycle: a software stop and the done pulse of a scan's final conversion. The bench waits for the converter model to raise done, and drives a write with bit 15 = 0 in that same cycle. The stop must win: no result write, no interrupt, and the start bit and the request both low afterwards. Triggers injected while a conversion is pending are a second kind of collision, and are judged by counting the result writes that follow.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CTRL_W = 16;
    localparam int DUP_W  = 5;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_GROUP  = 2'b01,
        MODE_CONT   = 2'b10,
        MODE_RSVD   = 2'b11
    } scan_mode_e;

    // Field positions follow the control word layout, MSB first.
    typedef struct packed {
        logic             start;
        scan_mode_e       mode;
        logic             end_ie;
        logic [1:0]       rsv_hi;
        logic             trig_en;
        logic             trig_ext;
        logic             dbl_en;
        logic             grpb_ie;
        logic             rsv_lo;
        logic [DUP_W-1:0] dup_sel;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_LAUNCH = 2'b01,
        ST_CONV   = 2'b10
    } seq_state_e;

    function automatic ctrl_t scrub_ctrl(input ctrl_t c);
        ctrl_t r;
        r        = c;
        r.rsv_hi = '0;
        r.rsv_lo = 1'b0;
        return r;
    endfunction

    function automatic logic is_one_shot(input scan_mode_e m);
        return (m == MODE_SINGLE) || (m == MODE_RSVD);
    endfunction

endpackage

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              hw_set,
    input  logic              auto_clr,
    output ctrl_t             ctrl,
    output logic [CTRL_W-1:0] rd_data,
    output logic              sw_start,
    output logic              sw_stop,
    output logic              dbl_enter
);

    ctrl_t ctrl_q;
    ctrl_t ctrl_d;
    ctrl_t wr_c;

    always_comb begin
        wr_c   = scrub_ctrl(ctrl_t'(wr_data));
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d = wr_c;
            if (wr_c.start) begin
                ctrl_d.dup_sel = ctrl_q.dup_sel;
            end
        end else if (hw_set) begin
            ctrl_d.start = 1'b1;
        end else if (auto_clr) begin
            ctrl_d.start = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl      = ctrl_q;
    assign rd_data   = ctrl_q;
    assign sw_start  = wr_en & wr_c.start;
    assign sw_stop   = wr_en & ~wr_c.start;
    assign dbl_enter = wr_en & wr_c.dbl_en & ~ctrl_q.dbl_en;

endmodule

// File: rtl/adc_ext_edge.sv
module adc_ext_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic fall
);

    // sh[0..SYNC_STAGES-1] synchronize, sh[SYNC_STAGES] holds the previous level.
    logic [SYNC_STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '1;
        end else begin
            sh <= {sh[SYNC_STAGES-1:0], pin_n};
        end
    end

    assign fall = sh[SYNC_STAGES] & ~sh[SYNC_STAGES-1];

endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
    parameter  int NCH = 16,
    localparam int CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask,
    input  logic [CHW-1:0] base,
    input  logic           incl,
    output logic           found,
    output logic [CHW-1:0] idx
);

    logic [NCH-1:0] elig;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_elig
            assign elig[g] = mask[g] &&
                             ((g > int'(base)) || (incl && (g == int'(base))));
        end
    endgenerate

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                idx   = CHW'(i);
            end
        end
    end

endmodule

// File: rtl/adc_scan_core.sv
module adc_scan_core
    import adc_seq_pkg::*;
#(
    parameter  int NCH   = 16,
    parameter  int RES_W = 12,
    localparam int CHW   = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [NCH-1:0]   chan_mask,
    input  logic             sw_start,
    input  logic             sw_stop,
    input  logic             dbl_enter,
    input  logic             hw_trig,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    output logic             conv_req,
    output logic [CHW-1:0]   conv_chan,
    output logic             res_wr_en,
    output logic [CHW-1:0]   res_wr_chan,
    output logic             res_wr_dup,
    output logic [RES_W-1:0] res_wr_data,
    output logic             end_irq,
    output logic             hw_set,
    output logic             auto_clr
);

    seq_state_e       st_q, st_d;
    logic [CHW-1:0]   cur_q, cur_d;
    logic             second_q, second_d;
    logic             dbl_q, dbl_d;
    logic             res_v_q, res_v_d;
    logic [CHW-1:0]   res_chan_q, res_chan_d;
    logic             res_dup_q, res_dup_d;
    logic [RES_W-1:0] res_data_q, res_data_d;
    logic             irq_q, irq_d;
    logic             finish;
    logic             fin_ok;

    logic             pick_found;
    logic [CHW-1:0]   pick_idx;
    logic [CHW-1:0]   pick_base;
    logic             pick_incl;

    assign pick_incl = (st_q == ST_LAUNCH);
    assign pick_base = pick_incl ? '0 : cur_q;

    adc_chan_pick #(.NCH(NCH)) u_pick (
        .mask  (chan_mask),
        .base  (pick_base),
        .incl  (pick_incl),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign hw_set = (st_q == ST_IDLE) && hw_trig && !sw_stop;

    always_comb begin
        st_d       = st_q;
        cur_d      = cur_q;
        second_d   = second_q;
        dbl_d      = dbl_q;
        res_v_d    = 1'b0;
        res_chan_d = res_chan_q;
        res_dup_d  = res_dup_q;
        res_data_d = res_data_q;
        irq_d      = 1'b0;
        finish     = 1'b0;
        fin_ok     = 1'b0;
        auto_clr   = 1'b0;

        case (st_q)
            ST_IDLE: begin
                if (sw_start || hw_trig) begin
                    st_d = ST_LAUNCH;
                end
            end
            ST_LAUNCH: begin
                dbl_d = ctrl.dbl_en;
                if (ctrl.dbl_en) begin
                    cur_d = ctrl.dup_sel[CHW-1:0];
                    st_d  = ST_CONV;
                end else if (pick_found) begin
                    cur_d = pick_idx;
                    st_d  = ST_CONV;
                end else begin
                    finish = 1'b1;
                    fin_ok = 1'b1;
                end
            end
            ST_CONV: begin
                if (conv_done) begin
                    res_v_d    = 1'b1;
                    res_chan_d = cur_q;
                    res_data_d = conv_result;
                    res_dup_d  = dbl_q & second_q;
                    if (dbl_q) begin
                        second_d = ~second_q;
                        finish   = 1'b1;
                        fin_ok   = second_q;
                    end else if (pick_found) begin
                        cur_d = pick_idx;
                    end else begin
                        finish = 1'b1;
                        fin_ok = 1'b1;
                    end
                end
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase

        if (finish) begin
            irq_d    = fin_ok & ctrl.end_ie;
            st_d     = ((ctrl.mode == MODE_CONT) || sw_start) ? ST_LAUNCH : ST_IDLE;
            auto_clr = is_one_shot(ctrl.mode);
        end

        if (dbl_enter) begin
            second_d = 1'b0;
        end

        if (sw_stop) begin
            st_d     = ST_IDLE;
            res_v_d  = 1'b0;
            irq_d    = 1'b0;
            second_d = 1'b0;
            auto_clr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            cur_q      <= '0;
            second_q   <= 1'b0;
            dbl_q      <= 1'b0;
            res_v_q    <= 1'b0;
            res_chan_q <= '0;
            res_dup_q  <= 1'b0;
            res_data_q <= '0;
            irq_q      <= 1'b0;
        end else begin
            st_q       <= st_d;
            cur_q      <= cur_d;
            second_q   <= second_d;
            dbl_q      <= dbl_d;
            res_v_q    <= res_v_d;
            res_chan_q <= res_chan_d;
            res_dup_q  <= res_dup_d;
            res_data_q <= res_data_d;
            irq_q      <= irq_d;
        end
    end

    assign conv_req    = (st_q == ST_CONV);
    assign conv_chan   = cur_q;
    assign res_wr_en   = res_v_q;
    assign res_wr_chan = res_chan_q;
    assign res_wr_dup  = res_dup_q;
    assign res_wr_data = res_data_q;
    assign end_irq     = irq_q;

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter  int NCH         = 16,
    parameter  int RES_W       = 12,
    parameter  int SYNC_STAGES = 2,
    localparam int CHW         = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr_en,
    input  logic [15:0]      reg_wr_data,
    output logic [15:0]      reg_rd_data,
    input  logic [NCH-1:0]   chan_mask,
    input  logic             sync_trig,
    input  logic             ext_trig_n,
    output logic             conv_req,
    output logic [CHW-1:0]   conv_chan,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    output logic             res_wr_en,
    output logic [CHW-1:0]   res_wr_chan,
    output logic             res_wr_dup,
    output logic [RES_W-1:0] res_wr_data,
    output logic             scan_end_irq
);

    ctrl_t ctrl;
    logic  sw_start;
    logic  sw_stop;
    logic  dbl_enter;
    logic  hw_set;
    logic  auto_clr;
    logic  ext_fall;
    logic  hw_trig;

    adc_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .wr_data   (reg_wr_data),
        .hw_set    (hw_set),
        .auto_clr  (auto_clr),
        .ctrl      (ctrl),
        .rd_data   (reg_rd_data),
        .sw_start  (sw_start),
        .sw_stop   (sw_stop),
        .dbl_enter (dbl_enter)
    );

    adc_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
        .clk   (clk),
        .rst   (rst),
        .pin_n (ext_trig_n),
        .fall  (ext_fall)
    );

    assign hw_trig = ctrl.trig_en & (ctrl.trig_ext ? ext_fall : sync_trig);

    adc_scan_core #(.NCH(NCH), .RES_W(RES_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .ctrl        (ctrl),
        .chan_mask   (chan_mask),
        .sw_start    (sw_start),
        .sw_stop     (sw_stop),
        .dbl_enter   (dbl_enter),
        .hw_trig     (hw_trig),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .conv_req    (conv_req),
        .conv_chan   (conv_chan),
        .res_wr_en   (res_wr_en),
        .res_wr_chan (res_wr_chan),
        .res_wr_dup  (res_wr_dup),
        .res_wr_data (res_wr_data),
        .end_irq     (scan_end_irq),
        .hw_set      (hw_set),
        .auto_clr    (auto_clr)
    );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
    parameter  int NCH   = 16,
    parameter  int RES_W = 12,
    localparam int CHW   = $clog2(NCH)
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr_en,
    input logic [15:0]      reg_wr_data,
    input logic [15:0]      reg_rd_data,
    input logic [NCH-1:0]   chan_mask,
    input logic             sync_trig,
    input logic             ext_trig_n,
    input logic             conv_req,
    input logic [CHW-1:0]   conv_chan,
    input logic             conv_done,
    input logic [RES_W-1:0] conv_result,
    input logic             res_wr_en,
    input logic [CHW-1:0]   res_wr_chan,
    input logic             res_wr_dup,
    input logic [RES_W-1:0] res_wr_data,
    input logic             scan_end_irq
);

    assert_irq_needs_enable_R13: assert property (@(posedge clk) disable iff (rst)
        scan_end_irq |-> $past(reg_rd_data[12]));

    assert_req_while_started_R5: assert property (@(posedge clk) disable iff (rst)
        conv_req |-> reg_rd_data[15]);

    assert_stop_aborts_R14: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && !reg_wr_data[15]) |=> (!conv_req && !res_wr_en && !scan_end_irq));

    assert_dbl_channel_R11: assert property (@(posedge clk) disable iff (rst)
        ($rose(conv_req) && $past(reg_rd_data[7])) |-> (conv_chan == $past(reg_rd_data[CHW-1:0])));

    assert_result_after_done_R4: assert property (@(posedge clk) disable iff (rst)
        res_wr_en |-> $past(conv_req && conv_done));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH), .RES_W(RES_W)) u_chk (.*);

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 16;
    localparam int RES_W = 12;
    localparam int CHW   = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             reg_wr_en = 1'b0;
    logic [15:0]      reg_wr_data = '0;
    logic [15:0]      reg_rd_data;
    logic [NCH-1:0]   chan_mask = '0;
    logic             sync_trig = 1'b0;
    logic             ext_trig_n = 1'b1;
    logic             conv_req;
    logic [CHW-1:0]   conv_chan;
    logic             conv_done = 1'b0;
    logic [RES_W-1:0] conv_result = '0;
    logic             res_wr_en;
    logic [CHW-1:0]   res_wr_chan;
    logic             res_wr_dup;
    logic [RES_W-1:0] res_wr_data;
    logic             scan_end_irq;

    int n_checks = 0;
    int n_errors = 0;
    int lat = 2;
    int lat_cnt = 0;
    int seq = 0;
    int irq_cnt = 0;
    int log_chan[$];
    int log_dup[$];
    int log_data[$];
    int model_data[$];
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_scan_seq #(.NCH(NCH), .RES_W(RES_W)) dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .chan_mask(chan_mask), .sync_trig(sync_trig),
        .ext_trig_n(ext_trig_n), .conv_req(conv_req), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_result(conv_result), .res_wr_en(res_wr_en),
        .res_wr_chan(res_wr_chan), .res_wr_dup(res_wr_dup), .res_wr_data(res_wr_data),
        .scan_end_irq(scan_end_irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Converter model: answers a pending request after lat cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (conv_done) begin
                conv_done = 1'b0;
            end else if (conv_req) begin
                lat_cnt++;
                if (lat_cnt >= lat) begin
                    lat_cnt     = 0;
                    conv_result = {seq[7:0], conv_chan};
                    seq++;
                    model_data.push_back(int'({seq[7:0] - 8'd1, conv_chan}));
                    conv_done   = 1'b1;
                end
            end else begin
                lat_cnt = 0;
            end
        end
    end

    // Output monitor.
    initial begin
        forever begin
            @(negedge clk);
            if (res_wr_en) begin
                log_chan.push_back(int'(res_wr_chan));
                log_dup.push_back(int'(res_wr_dup));
                log_data.push_back(int'(res_wr_data));
            end
            if (scan_end_irq) irq_cnt++;
        end
    end

    function automatic int nth_chan(input int mask, input int k);
        int n = 0;
        for (int c = 0; c < NCH; c++) begin
            if (mask[c]) begin
                if (n == k) return c;
                n++;
            end
        end
        return -1;
    endfunction

    function automatic int popc(input int mask);
        int n = 0;
        for (int c = 0; c < NCH; c++) n += mask[c];
        return n;
    endfunction

    task automatic clear_logs();
        @(negedge clk);
        log_chan.delete(); log_dup.delete(); log_data.delete(); model_data.delete();
        irq_cnt = 0;
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic pulse_sync();
        @(negedge clk);
        sync_trig = 1'b1;
        @(negedge clk);
        sync_trig = 1'b0;
    endtask

    task automatic wait_stopped(input string req);
        int n = 0;
        while (reg_rd_data[15] && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (n >= 400) check(1'b0, req, "start bit clear timeout", 1, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_logs(input int k, input int limit, input string req);
        int n = 0;
        while (log_chan.size() < k && n < limit) begin
            @(negedge clk);
            n++;
        end
        if (n >= limit) check(1'b0, req, "result count timeout", log_chan.size(), k);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_scan(input int mask, input string req);
        check(log_chan.size() == popc(mask), req, "result count", log_chan.size(), popc(mask));
        for (int i = 0; i < log_chan.size() && i < popc(mask); i++) begin
            check(log_chan[i] == nth_chan(mask, i), req, "channel order", log_chan[i], nth_chan(mask, i));
            check(log_data[i] == model_data[i], req, "result data", log_data[i], model_data[i]);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(reg_rd_data == 16'h0000, "R1", "control word", reg_rd_data, 0);
        check(!conv_req && !res_wr_en && !scan_end_irq, "R1", "outputs idle",
              {conv_req, res_wr_en, scan_end_irq}, 0);

        // R2: read-back with reserved bits forced to zero
        wr(16'h1FE5);
        check(reg_rd_data == 16'h13C5, "R2", "reserved bits", reg_rd_data, 16'h13C5);
        wr(16'h0C20);
        check(reg_rd_data == 16'h0000, "R2", "reserved only write", reg_rd_data, 0);

        // R3: channel field kept when start is written
        wr(16'h0003);
        chan_mask = 16'h0001;
        wr(16'h8007);
        check(reg_rd_data == 16'h8003, "R3", "dup field on start write", reg_rd_data, 16'h8003);
        wait_stopped("R3");

        // R4 R5 R13: random one-shot scans
        for (int it = 0; it < 24; it++) begin
            int m;
            int ie;
            logic [1:0] md;
            m  = (it % 6 == 5) ? 0 : int'($urandom() & 32'hFFFF);
            ie = int'($urandom() & 1);
            md = ($urandom() & 1) ? 2'b11 : 2'b00;
            lat = 1 + int'($urandom() % 3);
            clear_logs();
            chan_mask = m[NCH-1:0];
            wr({1'b1, md, ie[0], 12'h000});
            wait_stopped("R5");
            check(reg_rd_data[15] == 1'b0, "R5", "start cleared", reg_rd_data[15], 0);
            check_scan(m, "R4");
            check(irq_cnt == ie, "R13", "interrupt count", irq_cnt, ie);
        end
        lat = 2;

        // R6 R8: group mode with synchronous trigger
        chan_mask = 16'h0110;
        wr(16'h3200);
        clear_logs();
        pulse_sync();
        wait_logs(2, 60, "R6");
        check_scan(32'h0110, "R8");
        check(reg_rd_data[15] == 1'b1, "R6", "start kept after group scan", reg_rd_data[15], 1);
        check(irq_cnt == 1, "R13", "group interrupt", irq_cnt, 1);

        // R10: trigger during a conversion is ignored
        clear_logs();
        pulse_sync();
        while (!conv_req) @(negedge clk);
        pulse_sync();
        repeat (30) @(negedge clk);
        check(log_chan.size() == 2, "R10", "results with busy trigger", log_chan.size(), 2);
        check(irq_cnt == 1, "R10", "scans with busy trigger", irq_cnt, 1);

        // R8: trigger disabled
        wr(16'h2000);
        clear_logs();
        pulse_sync();
        repeat (20) @(negedge clk);
        check(log_chan.size() == 0 && !conv_req, "R8", "disabled trigger", log_chan.size(), 0);

        // R9 R8: external pin
        wr(16'h3300);
        clear_logs();
        @(negedge clk);
        #1 ext_trig_n = 1'b0;
        #3 ext_trig_n = 1'b1;
        repeat (15) @(negedge clk);
        check(log_chan.size() == 0, "R9", "short pulse ignored", log_chan.size(), 0);
        pulse_sync();
        repeat (15) @(negedge clk);
        check(log_chan.size() == 0, "R8", "unselected sync source", log_chan.size(), 0);
        @(negedge clk);
        #1 ext_trig_n = 1'b0;
        #15 ext_trig_n = 1'b1;
        wait_logs(2, 60, "R9");
        check_scan(32'h0110, "R9");
        check(reg_rd_data[15] == 1'b1, "R8", "trigger sets start", reg_rd_data[15], 1);
        wr(16'h0000);

        // R11 R12 R13: double-trigger mode, dup channel 5, mask ignored
        chan_mask = 16'h0001;
        wr(16'h1085);
        clear_logs();
        wr(16'h9085); wait_stopped("R11");
        wr(16'h9085); wait_stopped("R11");
        wr(16'h9085); wait_stopped("R11");
        check(log_chan.size() == 3, "R11", "one conversion per start", log_chan.size(), 3);
        for (int i = 0; i < log_chan.size() && i < 3; i++) begin
            check(log_chan[i] == 5, "R11", "dup channel", log_chan[i], 5);
            check(log_dup[i] == (i % 2), "R11", "destination alternates", log_dup[i], i % 2);
        end
        check(irq_cnt == 1, "R13", "interrupt after second only", irq_cnt, 1);
        wr(16'h1085);
        clear_logs();
        wr(16'h9085); wait_stopped("R12");
        check(log_dup.size() == 1 && log_dup[0] == 0, "R12", "toggle reset by stop",
              (log_dup.size() > 0) ? log_dup[0] : -1, 0);
        wr(16'h9005); wait_stopped("R12");
        clear_logs();
        wr(16'h9085); wait_stopped("R12");
        check(log_dup.size() == 1 && log_dup[0] == 0, "R12", "toggle reset on entry",
              (log_dup.size() > 0) ? log_dup[0] : -1, 0);

        // R7: continuous scan
        chan_mask = 16'h0006;
        clear_logs();
        wr(16'hD000);
        wait_logs(5, 100, "R7");
        check(reg_rd_data[15] == 1'b1, "R7", "start held while running", reg_rd_data[15], 1);
        for (int i = 0; i < 5; i++) begin
            check(log_chan[i] == ((i % 2) ? 2 : 1), "R7", "wrapping order", log_chan[i], (i % 2) ? 2 : 1);
        end
        check(irq_cnt >= 2, "R7", "repeated scan ends", irq_cnt, 2);
        wr(16'h4000);
        repeat (3) @(negedge clk);
        check(!conv_req && !reg_rd_data[15], "R14", "stopped continuous", {conv_req, reg_rd_data[15]}, 0);

        // R14: stop in the same cycle as the final done
        chan_mask = 16'h0001;
        clear_logs();
        wr(16'h9000);
        @(posedge conv_done);
        reg_wr_en = 1'b1;
        reg_wr_data = 16'h1000;
        @(negedge clk);
        reg_wr_en = 1'b0;
        repeat (5) @(negedge clk);
        check(model_data.size() == 1, "R14", "conversion completed", model_data.size(), 1);
        check(log_chan.size() == 0, "R14", "result suppressed", log_chan.size(), 0);
        check(irq_cnt == 0, "R14", "interrupt suppressed", irq_cnt, 0);
        check(!conv_req && !reg_rd_data[15], "R14", "idle after stop", {conv_req, reg_rd_data[15]}, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            check(1'b0, "watchdog", "run did not complete", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule